// File: doc/BRIEF.md
# Quad-Channel DAC Command Word Writer

This block is a transmit-only SPI master that loads an 8-bit code into one of four channels of a serial digital-to-analog converter. A one-cycle start pulse captures a 2-bit channel number and the 8-bit code. The block then builds a 16-bit command word. The word carries the channel address, a fixed "write the register and update the output" operation field, and the code split across the middle byte boundary.

The block drives the converter's active-low frame select low and shifts the word out most significant bit first. The serial clock idles high. Each bit is presented before a falling clock edge and advanced on the following rising edge. The select line is released only after the last bit has been clocked. A programmable half-period divider sets the serial clock rate. Busy and done outputs let the requesting logic know when another write may be issued. Nothing is read back from the converter.

Top module: `dac_word_writer`

## Requirements
- R1: After reset and between frames, `sync_n` is 1, `sck` is 1, `busy` is 0 and `done` is 0. `sck` is high whenever `sync_n` falls, so the first clock edge of a frame is a falling edge.
- R2: Command word bits [15:14] carry the channel number `chan_sel`, with 00, 01, 10 and 11 selecting the first to fourth channel.
- R3: Command word bits [13:12] are always 01, the write-and-update operation.
- R4: Command word bits [11:8] are `code[7:4]`, bits [7:4] are `code[3:0]`, and bits [3:0] are 0.
- R5: Each frame has exactly 16 falling `sck` edges while `sync_n` is low. The receiver samples `mosi` at those edges, and the word arrives bit 15 first.
- R6: While `sync_n` stays low, `mosi` changes only in the cycle where `sck` goes from 0 to 1.
- R7: Every `sck` level lasts `div_half+1` clock cycles. `sync_n` stays low for exactly 33*(`div_half`+1) cycles per frame. `div_half` is captured at start.
- R8: A start pulse while `busy` is 1 is ignored. `chan_sel`, `code` and `div_half` are captured when an accepted start occurs, so later changes do not alter the frame in progress.
- R9: `busy` is 1 from the cycle after an accepted start. `done` is a one-cycle pulse in the cycle where `sync_n` has returned to 1, and `busy` is already 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Write request pulse, accepted only when idle |
| chan_sel | input | 2 | Target channel number |
| code | input | 8 | Output code for the channel |
| div_half | input | DIV_W | Serial clock half period minus one, in clock cycles |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| sync_n | output | 1 | Active-low frame select to the converter |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the converter |

## Verification
The main check writes every code value to every channel at the fastest divider setting. It decodes each frame from `mosi` at the falling `sck` edges and compares the channel, operation and code fields against a word built arithmetically in the bench. A misplaced nibble, a swapped channel bit or a wrong operation constant therefore shows up in a specific field. Further frames at several divider settings compare the select-low duration with 33*(`div_half`+1), which separates a correct half-period count from an off-by-one error. A final frame is disturbed mid-transfer with a second start and with changed inputs. It shows that the captured word and the frame count are unaffected.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  localparam int CODE_W = 8;
  localparam int WORD_W = 16;
  localparam int CHAN_W = 2;
  localparam logic [1:0] OP_WRITE_UPDATE = 2'b01;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} wr_state_t;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [1:0]        op;
    logic [CODE_W-1:0] code;
    logic [3:0]        pad;
  } dac_cmd_t;
endpackage

// File: rtl/dacw_pack.sv
module dacw_pack
  import dacw_pkg::*;
(
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] word_o
);
  dac_cmd_t cmd;

  always_comb begin
    cmd.chan = chan_i;
    cmd.op   = OP_WRITE_UPDATE;
    cmd.code = code_i;
    cmd.pad  = '0;
    word_o   = cmd;
  end
endmodule

// File: rtl/dacw_tick.sv
module dacw_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] lim_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = en_i && (cnt_q == lim_i);
    if (!en_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: counter never runs past the programmed half period
  assert_tick_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q <= lim_i));
endmodule

// File: rtl/dacw_shreg.sv
module dacw_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] din_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_i)       sr_d = din_i;
    else if (shift_i) sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign msb_o = sr_q[W-1];

  // R8: loading and shifting never coincide
  assert_no_load_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && shift_i));
endmodule

// File: rtl/dac_word_writer.sv
module dac_word_writer
  import dacw_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       chan_sel,
  input  logic [7:0]       code,
  input  logic [DIV_W-1:0] div_half,
  output logic             busy,
  output logic             done,
  output logic             sync_n,
  output logic             sck,
  output logic             mosi
);
  localparam int HALVES = 2 * WORD_W + 1;
  localparam int HP_W   = $clog2(HALVES + 1);
  localparam logic [HP_W-1:0] HP_LAST  = HP_W'(HALVES - 1);
  localparam logic [HP_W-1:0] HP_SHEND = HP_W'(2 * WORD_W);

  wr_state_t        state_q, state_d;
  logic [HP_W-1:0]  hp_q, hp_d, hp_nx;
  logic [DIV_W-1:0] div_q, div_d;
  logic             sck_q, sck_d;
  logic             sync_q, sync_d;
  logic             done_q, done_d;
  logic             load, shift, tick, run;
  logic [WORD_W-1:0] word;

  dacw_pack u_pack (
    .chan_i (chan_sel),
    .code_i (code),
    .word_o (word)
  );

  dacw_tick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (run),
    .lim_i  (div_q),
    .tick_o (tick)
  );

  dacw_shreg #(.W(WORD_W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .shift_i (shift),
    .din_i   (word),
    .msb_o   (mosi)
  );

  assign run  = (state_q == ST_RUN);
  assign load = start && (state_q == ST_IDLE);
  assign hp_nx = hp_q + 1'b1;

  always_comb begin
    state_d = state_q;
    hp_d    = hp_q;
    div_d   = div_q;
    sck_d   = sck_q;
    sync_d  = sync_q;
    done_d  = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        sck_d  = 1'b1;
        sync_d = 1'b1;
        if (load) begin
          state_d = ST_RUN;
          hp_d    = '0;
          div_d   = div_half;
          sync_d  = 1'b0;
        end
      end
      ST_RUN: begin
        if (tick) begin
          hp_d = hp_nx;
          if (hp_q == HP_LAST) begin
            state_d = ST_IDLE;
            sync_d  = 1'b1;
            sck_d   = 1'b1;
            done_d  = 1'b1;
          end else if (hp_nx[0]) begin
            sck_d = 1'b0;
          end else begin
            sck_d = 1'b1;
            shift = (hp_nx < HP_SHEND);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hp_q    <= '0;
      div_q   <= '0;
      sck_q   <= 1'b1;
      sync_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hp_q    <= hp_d;
      div_q   <= div_d;
      sck_q   <= sck_d;
      sync_q  <= sync_d;
      done_q  <= done_d;
    end
  end

  assign busy   = run;
  assign done   = done_q;
  assign sync_n = sync_q;
  assign sck    = sck_q;

  // R1: clock idles high whenever the frame select is released
  assert_sck_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> sck);

  // R6: data moves only on a rising serial clock inside a frame
  assert_mosi_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && !$past(sync_n) && (mosi != $past(mosi))) |-> (sck && !$past(sck)));

  // R9: done follows the end of a frame, with busy already clear
  assert_done_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sync_n && !busy && !$past(sync_n)));

  // R9: done lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a start while busy does not open a new frame
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !$fell(sync_n));
endmodule

// File: tb/sim_dac_word_writer.sv
module sim_dac_word_writer;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] chan_sel = '0;
  logic [7:0] code = '0;
  logic [DIV_W-1:0] div_half = '0;
  logic busy, done, sync_n, sck, mosi;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dac_word_writer #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .code(code), .div_half(div_half), .busy(busy), .done(done),
    .sync_n(sync_n), .sck(sck), .mosi(mosi)
  );

  // serial-side monitor, sampled away from the active edge
  logic        p_sck = 1'b1, p_sync = 1'b1, p_mosi = 1'b0;
  logic [15:0] rx_word = '0;
  int          falls = 0, low_len = 0, frames = 0, mosi_bad = 0, sck_bad = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (p_sync && !sync_n) begin
        frames++;
        falls = 0; low_len = 0; rx_word = '0;
        if (!sck) sck_bad++;
      end
      if (!sync_n) begin
        low_len++;
        if (p_sck && !sck) begin
          rx_word = {rx_word[14:0], mosi};
          falls++;
        end
        if (!p_sync && (mosi != p_mosi) && !(sck && !p_sck)) mosi_bad++;
      end
    end
    p_sck = sck; p_sync = sync_n; p_mosi = mosi;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input int ch, input int cd, input int dv, input bit disturb);
    int exp_word;
    int f0;
    exp_word = (ch << 14) | (1 << 12) | (cd << 4);
    @(negedge clk);
    chan_sel = ch[1:0]; code = cd[7:0]; div_half = dv[DIV_W-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    if (disturb) begin
      repeat (7) @(negedge clk);
      chan_sel = ~ch[1:0]; code = ~cd[7:0]; div_half = DIV_W'(dv + 3); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(!busy && sync_n, "R9 busy clear at done", {busy, sync_n}, 1);
    check(rx_word[15:14] == exp_word[15:14], "R2 channel field", rx_word[15:14], exp_word[15:14]);
    check(rx_word[13:12] == 2'b01, "R3 operation field", rx_word[13:12], 1);
    check(rx_word[11:0] == exp_word[11:0], "R4 code field", rx_word[11:0], exp_word[11:0]);
    check(falls == 16, "R5 falling edge count", falls, 16);
    check(low_len == 33 * (dv + 1), "R7 select low length", low_len, 33 * (dv + 1));
    @(negedge clk);
    check(!done, "R9 done single cycle", done, 0);
    if (disturb) begin
      f0 = frames;
      repeat (40) @(negedge clk);
      check(frames == f0 && sync_n && !busy, "R8 no frame after ignored start", frames, f0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sync_n && sck && !busy && !done, "R1 reset state",
          {sync_n, sck, busy, done}, 4'b1100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sync_n && sck && !busy && !done, "R1 idle after reset",
          {sync_n, sck, busy, done}, 4'b1100);
    for (int ch = 0; ch < 4; ch++)
      for (int cd = 0; cd < 256; cd++)
        do_write(ch, cd, 0, 1'b0);
    for (int dv = 1; dv < 6; dv++) begin
      do_write(dv % 4, 8'hA5 ^ dv, dv, 1'b0);
      do_write(3 - (dv % 4), 8'h3C + dv, dv, 1'b0);
    end
    do_write(2, 8'h96, 2, 1'b1);
    check(sync_n && sck && !busy, "R1 idle between frames", {sync_n, sck, busy}, 3'b110);
    check(sck_bad == 0, "R1 sck high at select fall", sck_bad, 0);
    check(mosi_bad == 0, "R6 mosi changes only on rising sck", mosi_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(negedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule